// File: doc/BRIEF.md
# Vector Byte Table Lookup Permuter

This block produces a 128-bit vector in which every byte is chosen freely from a lookup table of one to four 128-bit registers. Each byte of an index vector gives the table position to fetch for the matching result lane, so any byte shuffle, gather or broadcast pattern can be expressed with a single operation. The table is supplied as one flat bus with the registers packed side by side, and a 2-bit count tells the block how many of them are live.

Index bytes that point past the end of the live table are resolved by a mode input. In zero-fill mode such lanes come out as zero. In keep mode they take the byte from the same lane of the previous destination value, which the caller supplies. This lets a wide table be split into chunks and looked up in passes, each pass filling in only the lanes it covers. The result is registered and appears one clock after the input strobe.

Top module: `vtbl_permuter`

## Requirements
- R1: Result lane i (bits 8i+7:8i) equals table byte k, where k is the unsigned value of index lane i, when k is in range. Table byte k sits in register k/16, byte k mod 16, and register r occupies bits 128r+127:128r of tbl_i.
- R2: tbl_cnt_i encodes the number of live registers as value+1 (2'b00 = 1 up to 2'b11 = 4). An index k is in range exactly when k < 16 * (tbl_cnt_i + 1), so with two registers 31 is in range and 32 is not.
- R3: With keep_mode_i = 0, a lane whose index is out of range gives 8'h00 (an index of 40 with two registers gives zero).
- R4: With keep_mode_i = 1, a lane whose index is out of range gives the byte of dest_i in the same lane.
- R5: Lanes are independent: one index vector may mix in-range and out-of-range lanes, and each lane follows R1, R3 or R4 on its own.
- R6: valid_o is high in the cycle after a clock edge that sampled valid_i high, and low after an edge that sampled valid_i low; result_o updates at the same edge.
- R7: While valid_i is low, result_o holds its last value regardless of the other inputs.
- R8: While rst_ni is low, valid_o and result_o are zero.
- R9: Index values from 64 to 255 are out of range for every table count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe: operands are sampled at this edge |
| idx_i | input | 128 | Index vector, one unsigned byte per lane |
| tbl_i | input | 512 | Lookup table, four 128-bit registers packed low to high |
| tbl_cnt_i | input | 2 | Live register count minus one |
| keep_mode_i | input | 1 | 0: out-of-range lanes give zero; 1: they keep dest_i |
| dest_i | input | 128 | Previous destination value for keep mode |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| result_o | output | 128 | Permuted result vector |

## Verification
A wrong range limit for one table count shows up in the very next result as a boundary lane (15/16, 31/32, 47/48, 63/64) taking a table byte where zero or the old destination byte belongs, or the reverse. A wrong byte selection or a swapped register slice shows as a single wrong lane on the first lookup that touches it, so the bench uses tables whose bytes are all distinct. A result or strobe register that loads at the wrong time shows one cycle later as a changed result during an idle cycle or a strobe that is high or low at the wrong edge.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int unsigned LANES    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MAX_REGS = 4;
  localparam int unsigned VEC_W    = LANES * BYTE_W;
  localparam int unsigned TBL_W    = VEC_W * MAX_REGS;
  localparam int unsigned CNT_W    = $clog2(MAX_REGS);

  typedef enum logic {
    OOR_ZERO = 1'b0,
    OOR_KEEP = 1'b1
  } oor_mode_e;
endpackage

// File: rtl/vtbl_range_chk.sv
module vtbl_range_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 16,
  parameter int unsigned CNT_W  = 2
) (
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              in_range_o
);
  logic [31:0] limit;

  // live bytes = lanes per register times (count field + 1)
  assign limit      = (32'(cnt_i) + 32'd1) * 32'(LANES);
  assign in_range_o = 32'(idx_i) < limit;
endmodule

// File: rtl/vtbl_byte_sel.sv
module vtbl_byte_sel #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned TBL_BYTES = 64
) (
  input  logic [TBL_BYTES*BYTE_W-1:0] tbl_i,
  input  logic [BYTE_W-1:0]           idx_i,
  output logic [BYTE_W-1:0]           byte_o
);
  localparam int unsigned SEL_W = $clog2(TBL_BYTES);

  logic [SEL_W-1:0] sel;

  // upper index bits only matter for the range check
  assign sel    = idx_i[SEL_W-1:0];
  assign byte_o = tbl_i[sel*BYTE_W +: BYTE_W];
endmodule

// File: rtl/vtbl_out_reg.sv
module vtbl_out_reg #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/vtbl_permuter.sv
module vtbl_permuter
  import vtbl_pkg::*;
#(
  parameter int unsigned N_LANES = vtbl_pkg::LANES,
  parameter int unsigned LANE_W  = vtbl_pkg::BYTE_W,
  parameter int unsigned N_REGS  = vtbl_pkg::MAX_REGS,
  localparam int unsigned V_W    = N_LANES * LANE_W,
  localparam int unsigned T_W    = V_W * N_REGS,
  localparam int unsigned C_W    = $clog2(N_REGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [V_W-1:0] idx_i,
  input  logic [T_W-1:0] tbl_i,
  input  logic [C_W-1:0] tbl_cnt_i,
  input  logic           keep_mode_i,
  input  logic [V_W-1:0] dest_i,
  output logic           valid_o,
  output logic [V_W-1:0] result_o
);
  localparam int unsigned T_BYTES = N_LANES * N_REGS;

  oor_mode_e      mode;
  logic [V_W-1:0] next_vec;

  assign mode = oor_mode_e'(keep_mode_i);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] idx_b;
    logic [LANE_W-1:0] tbl_b;
    logic              hit;

    assign idx_b = idx_i[g*LANE_W +: LANE_W];

    vtbl_range_chk #(
      .BYTE_W (LANE_W),
      .LANES  (N_LANES),
      .CNT_W  (C_W)
    ) u_range (
      .idx_i      (idx_b),
      .cnt_i      (tbl_cnt_i),
      .in_range_o (hit)
    );

    vtbl_byte_sel #(
      .BYTE_W    (LANE_W),
      .TBL_BYTES (T_BYTES)
    ) u_sel (
      .tbl_i  (tbl_i),
      .idx_i  (idx_b),
      .byte_o (tbl_b)
    );

    always_comb begin
      if (hit)                   next_vec[g*LANE_W +: LANE_W] = tbl_b;
      else if (mode == OOR_KEEP) next_vec[g*LANE_W +: LANE_W] = dest_i[g*LANE_W +: LANE_W];
      else                       next_vec[g*LANE_W +: LANE_W] = '0;
    end
  end

  vtbl_out_reg #(
    .VEC_W (V_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (next_vec),
    .valid_o (valid_o),
    .data_o  (result_o)
  );
endmodule

// File: rtl/vtbl_permuter_chk.sv
module vtbl_permuter_chk #(
  parameter int unsigned N_LANES = 16,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned N_REGS  = 4,
  localparam int unsigned V_W    = N_LANES * LANE_W,
  localparam int unsigned T_W    = V_W * N_REGS,
  localparam int unsigned C_W    = $clog2(N_REGS)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [V_W-1:0] idx_i,
  input logic [T_W-1:0] tbl_i,
  input logic [C_W-1:0] tbl_cnt_i,
  input logic           keep_mode_i,
  input logic [V_W-1:0] dest_i,
  input logic           valid_o,
  input logic [V_W-1:0] result_o
);
  // operands of the last accepted lookup
  logic           seen_q;
  logic [V_W-1:0] idx_q;
  logic [T_W-1:0] tbl_q;
  logic [V_W-1:0] dest_q;
  logic           keep_q;
  logic [31:0]    lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      idx_q  <= '0;
      tbl_q  <= '0;
      dest_q <= '0;
      keep_q <= 1'b0;
      lim_q  <= '0;
    end else begin
      seen_q <= valid_i;
      if (valid_i) begin
        idx_q  <= idx_i;
        tbl_q  <= tbl_i;
        dest_q <= dest_i;
        keep_q <= keep_mode_i;
        lim_q  <= (32'(tbl_cnt_i) + 32'd1) * 32'(N_LANES);
      end
    end
  end

  assert_strobe_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_strobe_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  always_comb begin
    if (!rst_ni) assert_reset_clear_R8: assert (valid_o == 1'b0 && result_o == '0);
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane_chk
    logic [LANE_W-1:0] ix;
    logic [LANE_W-1:0] res_b;
    logic              in_r;

    assign ix    = idx_q[g*LANE_W +: LANE_W];
    assign res_b = result_o[g*LANE_W +: LANE_W];
    assign in_r  = 32'(ix) < lim_q;

    assert_pick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && in_r) |-> res_b == tbl_q[32'(ix)*LANE_W +: LANE_W]);
    assert_zero_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !in_r && !keep_q) |-> res_b == '0);
    assert_keep_dest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !in_r && keep_q) |-> res_b == dest_q[g*LANE_W +: LANE_W]);
  end
endmodule

bind vtbl_permuter vtbl_permuter_chk #(
  .N_LANES (N_LANES),
  .LANE_W  (LANE_W),
  .N_REGS  (N_REGS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .idx_i       (idx_i),
  .tbl_i       (tbl_i),
  .tbl_cnt_i   (tbl_cnt_i),
  .keep_mode_i (keep_mode_i),
  .dest_i      (dest_i),
  .valid_o     (valid_o),
  .result_o    (result_o)
);

// File: tb/vtbl_permuter_tb.sv
`timescale 1ns/1ps
module vtbl_permuter_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] idx_i = '0;
  logic [511:0] tbl_i = '0;
  logic [1:0]   cnt_i = '0;
  logic         keep_i = 1'b0;
  logic [127:0] dest_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vtbl_permuter u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid_i),
    .idx_i       (idx_i),
    .tbl_i       (tbl_i),
    .tbl_cnt_i   (cnt_i),
    .keep_mode_i (keep_i),
    .dest_i      (dest_i),
    .valid_o     (valid_o),
    .result_o    (result_o)
  );

  function automatic logic [127:0] model(input logic [511:0] t, input logic [127:0] ix,
                                         input logic [1:0] c, input logic k,
                                         input logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int v;
      v = int'(ix[i*8 +: 8]);
      if (v < 16 * (int'(c) + 1)) r[i*8 +: 8] = t[(v / 16) * 128 + (v % 16) * 8 +: 8];
      else if (k)                 r[i*8 +: 8] = d[i*8 +: 8];
      else                        r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_table();
    for (int k = 0; k < 64; k++) tbl_i[k*8 +: 8] = 8'((k * 37 + 11) ^ 8'h5a);
  endtask

  // one lookup: drive at negedge, sample at next negedge after the capturing edge
  task automatic run_lookup(input string req);
    logic [127:0] exp;
    exp = model(tbl_i, idx_i, cnt_i, keep_i, dest_i);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, {127'd0, valid_o}, 128'd1);
    check(req, result_o, exp);
  endtask

  task automatic t_reset();
    check("R8 valid", {127'd0, valid_o}, 128'd0);
    check("R8 result", result_o, 128'd0);
  endtask

  task automatic t_identity();
    @(negedge clk);
    cnt_i = 2'b00; keep_i = 1'b0;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(15 - i);
    run_lookup("R1 single reg reverse");
  endtask

  task automatic t_four_regs();
    @(negedge clk);
    cnt_i = 2'b11; keep_i = 1'b0;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(63 - i * 4);
    run_lookup("R1 R2 four regs");
  endtask

  task automatic t_two_reg_zero();
    @(negedge clk);
    cnt_i = 2'b01; keep_i = 1'b0;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(20 + i);
    idx_i[7:0] = 8'd31; idx_i[15:8] = 8'd32; idx_i[23:16] = 8'd40;
    run_lookup("R2 R3 two regs zero-fill");
    check("R3 lane2 idx40", {120'd0, result_o[23:16]}, 128'd0);
    check("R2 lane0 idx31", {120'd0, result_o[7:0]}, {120'd0, tbl_i[128 + 15*8 +: 8]});
  endtask

  task automatic t_two_reg_keep();
    @(negedge clk);
    keep_i = 1'b1;
    for (int i = 0; i < 16; i++) dest_i[i*8 +: 8] = 8'(8'hc0 + i);
    run_lookup("R4 two regs keep");
    check("R4 lane1 idx32", {120'd0, result_o[15:8]}, {120'd0, 8'hc1});
  endtask

  task automatic t_mixed();
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      cnt_i = 2'b10; keep_i = 1'(m);
      for (int i = 0; i < 16; i++) begin
        idx_i[i*8 +: 8] = (i % 2 == 0) ? 8'(47 - i) : 8'(48 + i);
        dest_i[i*8 +: 8] = 8'(8'h90 ^ (i * 3));
      end
      run_lookup(m == 0 ? "R5 mixed zero-fill" : "R5 mixed keep");
    end
  endtask

  task automatic t_high_idx();
    @(negedge clk);
    cnt_i = 2'b11; keep_i = 1'b0;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(64 + i * 12);
    idx_i[127:120] = 8'hff;
    run_lookup("R9 high indices zero");
    @(negedge clk);
    keep_i = 1'b1;
    run_lookup("R9 high indices keep");
    check("R9 all dest", result_o, dest_i);
  endtask

  task automatic t_hold();
    logic [127:0] prev;
    prev = result_o;
    @(negedge clk);
    idx_i = ~idx_i; cnt_i = 2'b00; keep_i = 1'b0; dest_i = '0;
    @(negedge clk);
    @(negedge clk);
    check("R7 hold result", result_o, prev);
    check("R6 valid low", {127'd0, valid_o}, 128'd0);
  endtask

  task automatic t_back_to_back();
    logic [127:0] e1, e2;
    @(negedge clk);
    cnt_i = 2'b00; keep_i = 1'b0;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(i);
    e1 = model(tbl_i, idx_i, cnt_i, keep_i, dest_i);
    check("R6 valid before edge", {127'd0, valid_o}, 128'd0);
    valid_i = 1'b1;
    @(negedge clk);
    check("R6 first result", result_o, e1);
    cnt_i = 2'b11;
    for (int i = 0; i < 16; i++) idx_i[i*8 +: 8] = 8'(48 + i);
    e2 = model(tbl_i, idx_i, cnt_i, keep_i, dest_i);
    @(negedge clk);
    valid_i = 1'b0;
    check("R6 second result", result_o, e2);
    @(negedge clk);
    check("R6 valid drops", {127'd0, valid_o}, 128'd0);
  endtask

  initial begin
    fill_table();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_identity();
    t_four_regs();
    t_two_reg_zero();
    t_two_reg_keep();
    t_mixed();
    t_high_idx();
    t_hold();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule